// File: doc/BRIEF.md
# Shared Packet Buffer Allocator

This block hands out pages of a packet buffer shared by transmit and receive, with no fixed split between the two directions. A CPU-side transmit port and a MAC-side receive port each ask for room by stating a length in bytes. Either side may hand back a packet number to return that packet's pages to the pool. The block keeps the free-page count and a bitmap of used pages. A grant returns a packet number, which is the index of the first page of the allocation.

The CPU can change a transmit-reserve threshold at any time. While free memory does not exceed that threshold, new receive requests are refused, so the MAC drops those frames as overruns. Transmit requests ignore the threshold. A receive that was already granted keeps its pages when the threshold is raised. A zero threshold gives pure first-come first-served sharing of the whole pool. The free-page count and the pool size are exposed as read-only values.

Top module: `pkt_page_alloc`

## Requirements
- R1: A request for B bytes needs ceil(B/256) pages, and a 0-byte request needs one page. A request needing more than 8 pages gets a fail pulse and changes nothing.
- R2: A granted request takes the lowest-indexed free pages (page order 0 to 31), not necessarily contiguous. The packet number returned is the lowest of those indices.
- R3: A transmit request fails only when the pages it needs exceed the free pages. The reserve threshold has no effect on it.
- R4: A receive request is granted only if free pages exceed `tx_reserve` and the pages it needs do not exceed the free pages. Otherwise it fails.
- R5: With `tx_reserve` at zero, receive requests are served until the pool is exhausted, exactly like transmit.
- R6: A release of a packet number that heads a live allocation returns all of its pages. `free_pages` rises by that packet's page count at the same clock edge. A release of any other number leaves `free_pages` unchanged.
- R7: When transmit and receive request in the same cycle, the transmit result is reported first. The receive is judged one cycle later, against the updated free count.
- R8: Raising `tx_reserve` above the free count does not disturb a receive already granted. New receive requests fail until releases lift the free count above the threshold, and then succeed again.
- R9: After reset `free_pages` is 32 and `mem_pages` is 32. `free_pages` never exceeds `mem_pages`.
- R10: Each request yields exactly one result on the clock edge after the request cycle (one edge later for a deferred receive). The result is either a one-cycle `grant` pulse or a one-cycle `fail` pulse, never both. `result_rx` is 1 for a receive result and 0 for a transmit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_req | input | 1 | Transmit allocation request, one cycle per request |
| tx_bytes | input | 12 | Transmit length in bytes |
| rx_req | input | 1 | Receive allocation request, one cycle per request |
| rx_bytes | input | 12 | Receive length in bytes |
| rel_req | input | 1 | Release request |
| rel_pkt | input | 5 | Packet number to release |
| tx_reserve | input | 6 | Pages held back from receive |
| grant | output | 1 | Allocation granted pulse |
| fail | output | 1 | Allocation refused pulse |
| result_rx | output | 1 | Result belongs to receive (1) or transmit (0) |
| grant_pkt | output | 5 | Packet number of the grant |
| free_pages | output | 6 | Free page count |
| mem_pages | output | 6 | Total page count |

## Verification
The bench builds the block with its defaults: 32 pages of 256 bytes, an 8-page request cap and 12-bit lengths. The pool is small enough that a few 8-page requests drain it fully, which brings the exhausted-pool case within reach, along with a refused oversize request, a threshold sitting exactly at the free count, releases of non-head and unused numbers, and a release in the same cycle as an allocation. The same-cycle transmit and receive ordering is checked after a second reset.

// File: rtl/bufalloc_pkg.sv
package bufalloc_pkg;
  typedef enum logic {SIDE_TX = 1'b0, SIDE_RX = 1'b1} side_e;
endpackage

// File: rtl/bufalloc_pick.sv
// Chooses the lowest-indexed free pages for a request of `need` pages.
module bufalloc_pick #(
  parameter int NUM_PAGES = 32,
  parameter int NEED_W    = 4,
  parameter int PN_W      = 5
) (
  input  logic [NUM_PAGES-1:0] used_map,
  input  logic [NEED_W-1:0]    need,
  output logic [NUM_PAGES-1:0] take_mask,
  output logic [PN_W-1:0]      first_pg
);
  always_comb begin
    int  seen;
    logic found;
    seen      = 0;
    found     = 1'b0;
    take_mask = '0;
    first_pg  = '0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (!used_map[i]) begin
        if (seen < int'(need)) take_mask[i] = 1'b1;
        if (!found) begin
          first_pg = PN_W'(i);
          found    = 1'b1;
        end
        seen = seen + 1;
      end
    end
  end
endmodule

// File: rtl/bufalloc_table.sv
// Page bitmap, per-page owner, per-packet page count and free counter.
module bufalloc_table #(
  parameter int NUM_PAGES = 32,
  parameter int PN_W      = 5,
  parameter int CNT_W     = 6,
  parameter int NEED_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [NUM_PAGES-1:0] alloc_mask,
  input  logic [PN_W-1:0]      alloc_pkt,
  input  logic [NEED_W-1:0]    alloc_cnt,
  input  logic                 rel_req,
  input  logic [PN_W-1:0]      rel_pkt,
  output logic [NUM_PAGES-1:0] used_map,
  output logic [CNT_W-1:0]     free_cnt
);
  logic [NUM_PAGES-1:0] used_q, used_d;
  logic [NUM_PAGES-1:0] head_q, head_d;
  logic [NUM_PAGES-1:0] rel_mask;
  logic [PN_W-1:0]      owner_q [NUM_PAGES];
  logic [NEED_W-1:0]    pcnt_q  [NUM_PAGES];
  logic [CNT_W-1:0]     free_q, free_d;
  logic                 rel_ok;

  assign rel_ok = rel_req && head_q[rel_pkt];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    assign rel_mask[g] = rel_ok && used_q[g] && (owner_q[g] == rel_pkt);

    always_ff @(posedge clk) begin
      if (alloc_en && alloc_mask[g]) owner_q[g] <= alloc_pkt;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) pcnt_q[alloc_pkt] <= alloc_cnt;
  end

  always_comb begin
    used_d = used_q & ~rel_mask;
    head_d = head_q;
    if (rel_ok) head_d[rel_pkt] = 1'b0;
    if (alloc_en) begin
      used_d              = used_d | alloc_mask;
      head_d[alloc_pkt]   = 1'b1;
    end
    free_d = free_q
           + CNT_W'(rel_ok ? pcnt_q[rel_pkt] : '0)
           - CNT_W'(alloc_en ? alloc_cnt : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      head_q <= '0;
      free_q <= CNT_W'(NUM_PAGES);
    end else begin
      used_q <= used_d;
      head_q <= head_d;
      free_q <= free_d;
    end
  end

  assign used_map = used_q;
  assign free_cnt = free_q;

  // R6: the counter and the bitmap are kept by separate logic and must agree
  p_free_matches_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_q == CNT_W'(NUM_PAGES - $countones(used_q)));

  // R2: the selector only hands out pages that are free now
  p_take_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> ((alloc_mask & used_q) == '0));
endmodule

// File: rtl/bufalloc_admit.sv
// Arbitration between transmit and receive, page rounding and admission check.
module bufalloc_admit
  import bufalloc_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_PAGES  = 8,
  parameter int NEED_W     = 4,
  parameter int CNT_W      = 6,
  parameter int PN_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic [LEN_W-1:0]  tx_bytes,
  input  logic              rx_req,
  input  logic [LEN_W-1:0]  rx_bytes,
  input  logic [CNT_W-1:0]  reserve,
  input  logic [CNT_W-1:0]  free_cnt,
  input  logic [PN_W-1:0]   first_pg,
  output logic [NEED_W-1:0] need,
  output logic              alloc_en,
  output logic              grant_q,
  output logic              fail_q,
  output side_e             side_q,
  output logic [PN_W-1:0]   pkt_q
);
  localparam int PG_SH = $clog2(PAGE_BYTES);
  localparam int BIG_W = LEN_W + 1 - PG_SH;

  function automatic logic [BIG_W-1:0] pages_of(input logic [LEN_W-1:0] b);
    logic [LEN_W:0] r;
    r        = {1'b0, b} + (LEN_W+1)'(PAGE_BYTES - 1);
    pages_of = r[LEN_W:PG_SH];
    if (pages_of == '0) pages_of = BIG_W'(1);
  endfunction

  logic             pend_q, pend_d;
  logic [LEN_W-1:0] pend_len_q;
  logic             pend_load;
  logic             rx_act, serve_tx, serve_rx, big, fits, rx_room, ok;
  logic [LEN_W-1:0] rx_len, len_sel;
  logic [BIG_W-1:0] pg;
  logic             grant_d, fail_d;
  side_e            side_d;

  always_comb begin
    rx_act    = pend_q | rx_req;
    rx_len    = pend_q ? pend_len_q : rx_bytes;
    serve_tx  = tx_req;
    serve_rx  = !tx_req && rx_act;
    len_sel   = serve_tx ? tx_bytes : rx_len;
    pg        = pages_of(len_sel);
    big       = pg > BIG_W'(MAX_PAGES);
    need      = NEED_W'(pg);
    fits      = !big && (CNT_W'(need) <= free_cnt);
    rx_room   = free_cnt > reserve;
    ok        = serve_tx ? fits : (serve_rx && fits && rx_room);
    alloc_en  = ok;
    pend_load = tx_req && rx_act;
    pend_d    = pend_load;
    grant_d   = ok;
    fail_d    = (serve_tx || serve_rx) && !ok;
    side_d    = serve_rx ? SIDE_RX : SIDE_TX;
  end

  always_ff @(posedge clk) begin
    if (pend_load) pend_len_q <= rx_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
      fail_q  <= 1'b0;
      side_q  <= SIDE_TX;
      pkt_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      grant_q <= grant_d;
      fail_q  <= fail_d;
      side_q  <= side_d;
      if (grant_d) pkt_q <= first_pg;
    end
  end

  // R7: a transmit request always owns the very next result
  p_tx_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> ((grant_q || fail_q) && side_q == SIDE_TX));

  // R4: a receive grant implies free pages exceeded the threshold
  p_rx_reserve_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q && side_q == SIDE_RX) |-> ($past(free_cnt) > $past(reserve)));
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import bufalloc_pkg::*;
#(
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_PAGES  = 8,
  parameter int LEN_W      = 12,
  localparam int PN_W      = $clog2(NUM_PAGES),
  localparam int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_bytes,
  input  logic             rx_req,
  input  logic [LEN_W-1:0] rx_bytes,
  input  logic             rel_req,
  input  logic [PN_W-1:0]  rel_pkt,
  input  logic [CNT_W-1:0] tx_reserve,
  output logic             grant,
  output logic             fail,
  output logic             result_rx,
  output logic [PN_W-1:0]  grant_pkt,
  output logic [CNT_W-1:0] free_pages,
  output logic [CNT_W-1:0] mem_pages
);
  localparam int NEED_W = $clog2(MAX_PAGES + 1);

  logic [1:0]           rst_sync_q;
  logic                 rst_i_n;
  logic [NUM_PAGES-1:0] used_map, take_mask;
  logic [PN_W-1:0]      first_pg;
  logic [NEED_W-1:0]    need;
  logic                 alloc_en;
  logic [CNT_W-1:0]     free_cnt;
  side_e                side_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  bufalloc_admit #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_PAGES(MAX_PAGES),
    .NEED_W(NEED_W), .CNT_W(CNT_W), .PN_W(PN_W)
  ) u_admit (
    .clk(clk), .rst_n(rst_i_n),
    .tx_req(tx_req), .tx_bytes(tx_bytes),
    .rx_req(rx_req), .rx_bytes(rx_bytes),
    .reserve(tx_reserve), .free_cnt(free_cnt), .first_pg(first_pg),
    .need(need), .alloc_en(alloc_en),
    .grant_q(grant), .fail_q(fail), .side_q(side_q), .pkt_q(grant_pkt)
  );

  bufalloc_pick #(.NUM_PAGES(NUM_PAGES), .NEED_W(NEED_W), .PN_W(PN_W)) u_pick (
    .used_map(used_map), .need(need), .take_mask(take_mask), .first_pg(first_pg)
  );

  bufalloc_table #(
    .NUM_PAGES(NUM_PAGES), .PN_W(PN_W), .CNT_W(CNT_W), .NEED_W(NEED_W)
  ) u_table (
    .clk(clk), .rst_n(rst_i_n),
    .alloc_en(alloc_en), .alloc_mask(take_mask), .alloc_pkt(first_pg),
    .alloc_cnt(need), .rel_req(rel_req), .rel_pkt(rel_pkt),
    .used_map(used_map), .free_cnt(free_cnt)
  );

  assign result_rx  = (side_q == SIDE_RX);
  assign free_pages = free_cnt;
  assign mem_pages  = CNT_W'(NUM_PAGES);

  // R10: a result is a grant or a fail, never both
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({grant, fail}));

  // R9: the free count stays within the pool size
  p_free_bound_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    free_pages <= mem_pages);
endmodule

// File: tb/pkt_page_alloc_tb.sv
`timescale 1ns/1ps
module pkt_page_alloc_tb;
  typedef struct packed {
    logic        tx;   logic [11:0] txb;
    logic        rx;   logic [11:0] rxb;
    logic        rel;  logic [4:0]  relp;
    logic [5:0]  res;
    logic        eg;   logic        ef;   logic es;
    logic [4:0]  ep;   logic [5:0]  efree;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1,12'd256, 1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b0,5'd0, 6'd31, 4'd2},  // R2 first grant
    '{1'b1,12'd1000,1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b0,5'd1, 6'd27, 4'd1},  // R1 1000B -> 4 pages
    '{1'b0,12'd0,   1'b1,12'd1,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b1,5'd5, 6'd26, 4'd5},  // R5 rx with zero reserve
    '{1'b1,12'd2049,1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b0,1'b1,1'b0,5'd0, 6'd26, 4'd1},  // R1 9 pages refused
    '{1'b0,12'd0,   1'b0,12'd0,   1'b1,5'd1, 6'd0,  1'b0,1'b0,1'b0,5'd0, 6'd30, 4'd6},  // R6 release 4 pages
    '{1'b0,12'd0,   1'b1,12'd0,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b1,5'd1, 6'd29, 4'd1},  // R1 zero bytes -> 1 page
    '{1'b0,12'd0,   1'b1,12'd100, 1'b0,5'd0, 6'd29, 1'b0,1'b1,1'b1,5'd0, 6'd29, 4'd4},  // R4 free == reserve
    '{1'b1,12'd512, 1'b0,12'd0,   1'b0,5'd0, 6'd29, 1'b1,1'b0,1'b0,5'd2, 6'd27, 4'd3},  // R3 tx ignores reserve
    '{1'b0,12'd0,   1'b0,12'd0,   1'b1,5'd2, 6'd29, 1'b0,1'b0,1'b0,5'd0, 6'd29, 4'd6},  // R6
    '{1'b0,12'd0,   1'b1,12'd300, 1'b0,5'd0, 6'd28, 1'b1,1'b0,1'b1,5'd2, 6'd27, 4'd4},  // R4 free above reserve
    '{1'b0,12'd0,   1'b0,12'd0,   1'b1,5'd7, 6'd28, 1'b0,1'b0,1'b0,5'd0, 6'd27, 4'd6},  // R6 unused number
    '{1'b0,12'd0,   1'b0,12'd0,   1'b1,5'd3, 6'd28, 1'b0,1'b0,1'b0,5'd0, 6'd27, 4'd6},  // R6 non-head page
    '{1'b1,12'd256, 1'b0,12'd0,   1'b1,5'd0, 6'd0,  1'b1,1'b0,1'b0,5'd4, 6'd27, 4'd6},  // R6 release with alloc
    '{1'b1,12'd2048,1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b0,5'd0, 6'd19, 4'd2},  // R2 scattered pages
    '{1'b1,12'd2048,1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b0,5'd13,6'd11, 4'd3},
    '{1'b1,12'd2048,1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b0,5'd21,6'd3,  4'd3},
    '{1'b1,12'd1024,1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b0,1'b1,1'b0,5'd0, 6'd3,  4'd3},  // R3 need > free
    '{1'b0,12'd0,   1'b1,12'd768, 1'b0,5'd0, 6'd0,  1'b1,1'b0,1'b1,5'd29,6'd0,  4'd5},  // R5 drains pool
    '{1'b0,12'd0,   1'b1,12'd1,   1'b0,5'd0, 6'd0,  1'b0,1'b1,1'b1,5'd0, 6'd0,  4'd5},  // R5 empty pool
    '{1'b0,12'd0,   1'b0,12'd0,   1'b0,5'd0, 6'd0,  1'b0,1'b0,1'b0,5'd0, 6'd0,  4'd10}  // R10 pulse ends
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_req, rx_req, rel_req;
  logic [11:0] tx_bytes, rx_bytes;
  logic [4:0]  rel_pkt;
  logic [5:0]  tx_reserve;
  logic        grant, fail, result_rx;
  logic [4:0]  grant_pkt;
  logic [5:0]  free_pages, mem_pages;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done  = 1'b0;

  always #2.5 clk = ~clk;

  pkt_page_alloc u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .tx_bytes(tx_bytes),
    .rx_req(rx_req), .rx_bytes(rx_bytes),
    .rel_req(rel_req), .rel_pkt(rel_pkt), .tx_reserve(tx_reserve),
    .grant(grant), .fail(fail), .result_rx(result_rx), .grant_pkt(grant_pkt),
    .free_pages(free_pages), .mem_pages(mem_pages)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    tx_req = 1'b0; rx_req = 1'b0; rel_req = 1'b0;
    tx_bytes = '0; rx_bytes = '0; rel_pkt = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    tx_reserve = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 free after reset", free_pages, 32);
    chk("R9 mem size", mem_pages, 32);
    chk("R10 no grant at reset", grant, 0);
    chk("R10 no fail at reset", fail, 0);

    for (int i = 0; i < NV; i++) begin
      tx_req = VECS[i].tx;  tx_bytes = VECS[i].txb;
      rx_req = VECS[i].rx;  rx_bytes = VECS[i].rxb;
      rel_req = VECS[i].rel; rel_pkt = VECS[i].relp;
      tx_reserve = VECS[i].res;
      @(negedge clk);
      chk($sformatf("vec %0d R%0d grant", i, VECS[i].rq), grant, VECS[i].eg);
      chk($sformatf("vec %0d R%0d fail", i, VECS[i].rq), fail, VECS[i].ef);
      chk($sformatf("vec %0d R%0d free", i, VECS[i].rq), free_pages, VECS[i].efree);
      if (VECS[i].eg || VECS[i].ef)
        chk($sformatf("vec %0d R%0d side", i, VECS[i].rq), result_rx, VECS[i].es);
      if (VECS[i].eg)
        chk($sformatf("vec %0d R%0d pkt", i, VECS[i].rq), grant_pkt, VECS[i].ep);
    end

    // R7 same-cycle transmit and receive
    do_reset();
    tx_req = 1'b1; tx_bytes = 12'd256; rx_req = 1'b1; rx_bytes = 12'd256;
    @(negedge clk);
    idle();
    chk("R7 tx first grant", grant, 1);
    chk("R7 tx first side", result_rx, 0);
    chk("R7 tx first pkt", grant_pkt, 0);
    chk("R7 free after tx", free_pages, 31);
    @(negedge clk);
    chk("R7 rx deferred grant", grant, 1);
    chk("R7 rx deferred side", result_rx, 1);
    chk("R7 rx deferred pkt", grant_pkt, 1);
    chk("R7 free after rx", free_pages, 30);

    // R8 threshold raised above free count after a receive was granted
    tx_reserve = 6'd31;
    rel_req = 1'b1; rel_pkt = 5'd1;
    @(negedge clk);
    idle();
    chk("R8 granted rx still held then released", free_pages, 31);
    rx_req = 1'b1; rx_bytes = 12'd1;
    @(negedge clk);
    idle();
    chk("R8 new rx refused", fail, 1);
    chk("R8 refused side", result_rx, 1);
    rel_req = 1'b1; rel_pkt = 5'd0;
    @(negedge clk);
    idle();
    chk("R8 free recovers", free_pages, 32);
    rx_req = 1'b1; rx_bytes = 12'd1;
    @(negedge clk);
    idle();
    chk("R8 rx accepted again", grant, 1);
    chk("R8 rx pkt", grant_pkt, 0);
    chk("R8 free after rx", free_pages, 31);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule